// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block paces a display pipe. It produces horizontal sync, vertical sync and an active-video enable, together with the current pixel and line positions. A pixel-clock enable, derived from the system clock by a programmable integer ratio, advances the raster. A small write-only register port sets the sync width, back porch, active size and front porch of each axis, the clock ratio, a line-compare value and the control bits. Every length is written as the real count minus one.

Timing writes go to holding registers. The generator copies them into its working set only at a frame boundary, or at any cycle while it is idle. A frame in flight therefore never mixes old and new geometry. The video-enable bit is staged the same way: clearing it lets the current frame run to its last pixel, and then the outputs go quiet. The block raises a latched frame interrupt when vertical sync starts, and a one-pixel pulse when the line counter reaches the compare value. A write of one clears the interrupt.

Top module: `raster_tgen`

## Requirements
- R1: During and after reset, and while video is not enabled, hsync, vsync, de, pix_ce, line_match and frame_irq are 0, and h_pos and v_pos are 0.
- R2: Each line is hsync (sync pixels), then back porch, then active, then front porch, and h_pos counts 0 to htotal-1. The widths are written minus one: address 0 holds sync in bits [11:0] and back porch in bits [27:16], and address 1 holds active in bits [11:0] and front porch in bits [27:16]. hsync is high while h_pos is below the sync width.
- R3: Each frame is vsync lines, back porch lines, active lines and front porch lines, in that order, and v_pos counts 0 to vtotal-1. The fields are written minus one: address 2 holds sync in [11:0] and back porch in [27:16], and address 3 holds active in [11:0] and front porch in [27:16].
- R4: de is high exactly when both h_pos and v_pos are inside their active regions.
- R5: Address 4 bits [7:0] hold the ratio N minus one, for N from 1 to 256. pix_ce is high one cycle in every N, counted from frame start, and h_pos and v_pos change only after a cycle with pix_ce high.
- R6: Timing, ratio and line-compare writes made during a frame have no effect on that frame. They apply from the next frame start.
- R7: Address 6 bit 0 is video enable. Setting it while idle starts a frame at h_pos=0, v_pos=0 with hsync and vsync high. Clearing it lets the current frame finish in full, and then the outputs stay idle.
- R8: Address 5 holds a line number. line_match is high for the single cycle in which v_pos equals it, h_pos is 0 and pix_ce is high.
- R9: Address 6 bit 1 is the master interrupt enable and bit 2 is the frame interrupt enable. frame_irq goes high on the cycle after vsync rises, but only when both bits are set.
- R10: Writing address 7 with bit 0 set clears frame_irq. Writing it with bit 0 at 0 leaves frame_irq unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Register write data |
| pix_ce | output | 1 | Pixel clock enable |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Active-video enable |
| h_pos | output | TW+2 | Pixel position within the line |
| v_pos | output | TW+2 | Line position within the frame |
| line_match | output | 1 | Line-compare pulse |
| frame_irq | output | 1 | Latched frame interrupt |

## Verification
The bench compares every output cycle by cycle over whole frames against a raster computed from the programmed geometry. It does this for ratios of 1, 3 and the 256 maximum, so an off-by-one in any minus-one field, or a divider that counts one cycle too many, shows up as a shifted edge. It rewrites the whole geometry in the middle of a frame and measures the length of that frame: a design that applied the writes at once would give a frame of the wrong length. It clears video enable mid-frame and counts the hsync pulses that follow; a design that stopped at once would lose lines, and one that did not stop would start another vsync. The interrupt is tried with only one of the two enables set and with both set, and the clear bit is written both as zero and as one.

// File: rtl/rtg_pkg.sv
// Shared constants for the raster timing generator: register addresses,
// field positions and control bit positions.
package rtg_pkg;

    // Register addresses of the write port
    typedef enum logic [2:0] {
        ADR_H_SYNC_BP  = 3'd0,
        ADR_H_ACT_FP   = 3'd1,
        ADR_V_SYNC_BP  = 3'd2,
        ADR_V_ACT_FP   = 3'd3,
        ADR_DIVIDER    = 3'd4,
        ADR_LINE_CMP   = 3'd5,
        ADR_CONTROL    = 3'd6,
        ADR_IRQ_CLEAR  = 3'd7
    } rtg_addr_e;

    // Bit position of the upper field in a two-field timing word
    localparam int HI_FIELD_LSB = 16;

    // Control register bits
    localparam int CTL_VIDEO_EN = 0;
    localparam int CTL_IRQ_MSTR = 1;
    localparam int CTL_IRQ_FRM  = 2;

    // Index of each timing field in the staged field array
    localparam int F_HSYNC = 0;
    localparam int F_HBP   = 1;
    localparam int F_HACT  = 2;
    localparam int F_HFP   = 3;
    localparam int F_VSYNC = 4;
    localparam int F_VBP   = 5;
    localparam int F_VACT  = 6;
    localparam int F_VFP   = 7;
    localparam int N_FIELDS = 8;

endpackage

// File: rtl/rtg_regs.sv
// Register file with frame-boundary staging.
// Writes land in holding registers. The working copy (timing fields,
// ratio, line compare and the run flag) is refreshed from the holding
// copy when the raster is idle or on the last pixel of a frame.
// Interrupt enables take effect at once. The clear strobe is combinational.
// Assumes TW <= 16 so two fields fit in one 32-bit word.
module rtg_regs
    import rtg_pkg::*;
#(
    parameter int TW = 12,
    parameter int DW = 8,
    parameter int PW = TW + 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [2:0]                    addr,
    input  logic [31:0]                   wdata,
    input  logic                          frame_end,
    output logic [N_FIELDS-1:0][TW-1:0]   tim,
    output logic [DW-1:0]                 div_m1,
    output logic [PW-1:0]                 line_cmp,
    output logic                          run,
    output logic                          irq_mstr,
    output logic                          irq_frm,
    output logic                          irq_clr
);

    logic [N_FIELDS-1:0][TW-1:0] hold_tim;
    logic [DW-1:0]               hold_div;
    logic [PW-1:0]               hold_cmp;
    logic                        hold_ven;
    logic                        apply;
    rtg_addr_e                   sel;
    logic                        unused_wdata;

    assign sel          = rtg_addr_e'(addr);
    assign unused_wdata = ^wdata;

    // Working copy may be refreshed while idle or at the end of a frame
    assign apply = ~run | frame_end;

    // Holding registers and immediate control bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_tim <= '0;
            hold_div <= '0;
            hold_cmp <= '0;
            hold_ven <= 1'b0;
            irq_mstr <= 1'b0;
            irq_frm  <= 1'b0;
        end else if (we) begin
            case (sel)
                ADR_H_SYNC_BP: begin
                    hold_tim[F_HSYNC] <= wdata[TW-1:0];
                    hold_tim[F_HBP]   <= wdata[HI_FIELD_LSB +: TW];
                end
                ADR_H_ACT_FP: begin
                    hold_tim[F_HACT]  <= wdata[TW-1:0];
                    hold_tim[F_HFP]   <= wdata[HI_FIELD_LSB +: TW];
                end
                ADR_V_SYNC_BP: begin
                    hold_tim[F_VSYNC] <= wdata[TW-1:0];
                    hold_tim[F_VBP]   <= wdata[HI_FIELD_LSB +: TW];
                end
                ADR_V_ACT_FP: begin
                    hold_tim[F_VACT]  <= wdata[TW-1:0];
                    hold_tim[F_VFP]   <= wdata[HI_FIELD_LSB +: TW];
                end
                ADR_DIVIDER:  hold_div <= wdata[DW-1:0];
                ADR_LINE_CMP: hold_cmp <= wdata[PW-1:0];
                ADR_CONTROL: begin
                    hold_ven <= wdata[CTL_VIDEO_EN];
                    irq_mstr <= wdata[CTL_IRQ_MSTR];
                    irq_frm  <= wdata[CTL_IRQ_FRM];
                end
                default: ;
            endcase
        end
    end

    // Working copy, loaded only at a frame boundary or while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tim      <= '0;
            div_m1   <= '0;
            line_cmp <= '0;
            run      <= 1'b0;
        end else if (apply) begin
            tim      <= hold_tim;
            div_m1   <= hold_div;
            line_cmp <= hold_cmp;
            run      <= hold_ven;
        end
    end

    // Write-one clear strobe for the interrupt flag
    assign irq_clr = we && (sel == ADR_IRQ_CLEAR) && wdata[0];

endmodule

// File: rtl/rtg_clkdiv.sv
// Integer pixel-clock enable generator.
// Produces one enable pulse every (div_m1 + 1) cycles while run is high.
// The count restarts from zero whenever run is low, so the first pulse
// of a frame comes div_m1 cycles after the frame starts.
module rtg_clkdiv #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [DW-1:0] div_m1,
    output logic          ce
);

    logic [DW-1:0] cnt;
    logic          wrap;

    assign wrap = (cnt == div_m1);

    // Cycle counter within one pixel period
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (wrap) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign ce = run & wrap;

endmodule

// File: rtl/rtg_axis.sv
// One raster axis: a position counter that runs through sync, back porch,
// active and front porch, then wraps. All lengths come in as count minus one.
// The position is held at zero while run is low and advances on step.
module rtg_axis #(
    parameter int TW = 12,
    parameter int PW = TW + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          step,
    input  logic [TW-1:0] sync_m1,
    input  logic [TW-1:0] bp_m1,
    input  logic [TW-1:0] act_m1,
    input  logic [TW-1:0] fp_m1,
    output logic [PW-1:0] pos,
    output logic          in_sync,
    output logic          in_act,
    output logic          at_last
);

    logic [PW-1:0] end_sync;
    logic [PW-1:0] end_bp;
    logic [PW-1:0] end_act;
    logic [PW-1:0] last_idx;

    // Region edges computed from the minus-one lengths
    always_comb begin
        end_sync = PW'(sync_m1) + PW'(1);
        end_bp   = end_sync + PW'(bp_m1) + PW'(1);
        end_act  = end_bp + PW'(act_m1) + PW'(1);
        last_idx = end_act + PW'(fp_m1);
    end

    assign at_last = (pos == last_idx);

    // Position counter with wrap at the end of the axis
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pos <= '0;
        end else if (step) begin
            pos <= at_last ? '0 : pos + 1'b1;
        end
    end

    assign in_sync = run && (pos < end_sync);
    assign in_act  = run && (pos >= end_bp) && (pos < end_act);

endmodule

// File: rtl/rtg_irq.sv
// Frame interrupt flag. It is set on the cycle after vsync rises when both
// enables are high, and cleared by the write-one strobe. Set wins over clear.
module rtg_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic vsync,
    input  logic irq_mstr,
    input  logic irq_frm,
    input  logic clr,
    output logic pending
);

    logic vsync_q;
    logic set_evt;

    // Delayed vsync for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) vsync_q <= 1'b0;
        else        vsync_q <= vsync;
    end

    assign set_evt = vsync & ~vsync_q & irq_mstr & irq_frm;

    // Pending flag with set priority
    always_ff @(posedge clk) begin
        if (!rst_n)       pending <= 1'b0;
        else if (set_evt) pending <= 1'b1;
        else if (clr)     pending <= 1'b0;
    end

endmodule

// File: rtl/raster_tgen.sv
// Programmable raster timing generator, top level.
// Combines the staged register file, the pixel-clock enable divider, one
// counter per axis (built by a generate loop), the line compare and the
// frame interrupt. Sync outputs are active high. Assumes every programmed
// length is at least one, which the minus-one encoding guarantees.
module raster_tgen
    import rtg_pkg::*;
#(
    parameter int  TW = 12,
    parameter int  DW = 8,
    localparam int PW = TW + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_addr,
    input  logic [31:0]   cfg_wdata,
    output logic          pix_ce,
    output logic          hsync,
    output logic          vsync,
    output logic          de,
    output logic [PW-1:0] h_pos,
    output logic [PW-1:0] v_pos,
    output logic          line_match,
    output logic          frame_irq
);

    localparam int N_AXES = 2;

    logic [N_FIELDS-1:0][TW-1:0] tim;
    logic [DW-1:0]               div_m1;
    logic [PW-1:0]               line_cmp;
    logic                        run;
    logic                        irq_mstr;
    logic                        irq_frm;
    logic                        irq_clr;
    logic                        frame_end;

    logic [PW-1:0] ax_pos  [N_AXES];
    logic          ax_sync [N_AXES];
    logic          ax_act  [N_AXES];
    logic          ax_last [N_AXES];
    logic          ax_step [N_AXES];

    rtg_regs #(.TW(TW), .DW(DW), .PW(PW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .frame_end (frame_end),
        .tim       (tim),
        .div_m1    (div_m1),
        .line_cmp  (line_cmp),
        .run       (run),
        .irq_mstr  (irq_mstr),
        .irq_frm   (irq_frm),
        .irq_clr   (irq_clr)
    );

    rtg_clkdiv #(.DW(DW)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .div_m1 (div_m1),
        .ce     (pix_ce)
    );

    // The horizontal axis steps on every pixel, the vertical on line wrap
    assign ax_step[0] = pix_ce;
    assign ax_step[1] = pix_ce & ax_last[0];

    // One counter per axis; axis g uses fields 4*g .. 4*g+3
    for (genvar g = 0; g < N_AXES; g++) begin : g_axis
        rtg_axis #(.TW(TW), .PW(PW)) u_axis (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (run),
            .step    (ax_step[g]),
            .sync_m1 (tim[4*g + 0]),
            .bp_m1   (tim[4*g + 1]),
            .act_m1  (tim[4*g + 2]),
            .fp_m1   (tim[4*g + 3]),
            .pos     (ax_pos[g]),
            .in_sync (ax_sync[g]),
            .in_act  (ax_act[g]),
            .at_last (ax_last[g])
        );
    end

    // Last pixel of the last line is the only staging point while running
    assign frame_end = pix_ce & ax_last[0] & ax_last[1];

    assign h_pos = ax_pos[0];
    assign v_pos = ax_pos[1];
    assign hsync = ax_sync[0];
    assign vsync = ax_sync[1];
    assign de    = ax_act[0] & ax_act[1];

    // Line compare: first pixel of the selected line, one enable wide
    assign line_match = pix_ce && (ax_pos[0] == '0) && (ax_pos[1] == line_cmp);

    rtg_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .vsync    (ax_sync[1]),
        .irq_mstr (irq_mstr),
        .irq_frm  (irq_frm),
        .clr      (irq_clr),
        .pending  (frame_irq)
    );

endmodule

// File: rtl/rtg_checker.sv
// Port-level properties of the raster timing generator, bound to the top.
module rtg_checker #(
    parameter int TW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pix_ce,
    input logic          hsync,
    input logic          vsync,
    input logic          de,
    input logic [TW+1:0] h_pos,
    input logic [TW+1:0] v_pos,
    input logic          line_match,
    input logic          frame_irq
);

    AST_DE_CLEAR_OF_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (!hsync && !vsync)); // R4

    AST_POS_ONLY_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_ce |=> ($stable(h_pos) && $stable(v_pos))); // R5

    AST_LINE_MATCH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        line_match |=> !line_match); // R8

    AST_IRQ_FOLLOWS_VSYNC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_irq) |-> (vsync && $past(vsync))); // R9

    AST_SYNC_STARTS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vsync) |-> (h_pos == '0 && v_pos == '0 && hsync)); // R3

endmodule

bind raster_tgen rtg_checker #(.TW(TW)) u_rtg_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_ce     (pix_ce),
    .hsync      (hsync),
    .vsync      (vsync),
    .de         (de),
    .h_pos      (h_pos),
    .v_pos      (v_pos),
    .line_match (line_match),
    .frame_irq  (frame_irq)
);

// File: tb/raster_tgen_test.sv
// Directed bench for raster_tgen: one task per scenario, with a per-cycle
// raster model computed from the programmed geometry.
module raster_tgen_test;

    localparam int TW = 12;
    localparam int PW = TW + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic          pix_ce, hsync, vsync, de, line_match, frame_irq;
    logic [PW-1:0] h_pos, v_pos;

    int vectors = 0;
    int miscompares = 0;
    longint cyc = 0;
    longint t_rise = 0;
    bit done = 0;

    int D, HS, HBP, HA, HFP, VS, VBP, VA, VFP, THR;

    raster_tgen #(.TW(TW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pix_ce(pix_ce), .hsync(hsync), .vsync(vsync),
        .de(de), .h_pos(h_pos), .v_pos(v_pos), .line_match(line_match),
        .frame_irq(frame_irq)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int htot();
        return HS + HBP + HA + HFP;
    endfunction
    function automatic int vtot();
        return VS + VBP + VA + VFP;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Called at a negedge; one register write, returns one cycle later at a negedge
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    task automatic program_cfg();
        wr(3'd0, ((HBP - 1) << 16) | (HS - 1));
        wr(3'd1, ((HFP - 1) << 16) | (HA - 1));
        wr(3'd2, ((VBP - 1) << 16) | (VS - 1));
        wr(3'd3, ((VFP - 1) << 16) | (VA - 1));
        wr(3'd4, D - 1);
        wr(3'd5, THR);
    endtask

    task automatic wait_rise();
        while (vsync !== 1'b0) @(negedge clk);
        while (vsync !== 1'b1) @(negedge clk);
        t_rise = cyc;
    endtask

    // Compares every output over one frame; entered at frame cycle 0
    task automatic check_body();
        string tags [7] = '{"R2", "R3", "R4", "R2", "R3", "R5", "R8"};
        string names[7] = '{"hsync", "vsync", "de", "h_pos", "v_pos", "pix_ce", "line_match"};
        int nbad[7];
        longint fa[7], fe[7];
        longint a[7], e[7];
        int total;
        total = D * htot() * vtot();
        for (int j = 0; j < 7; j++) begin nbad[j] = 0; fa[j] = 0; fe[j] = 0; end
        for (int k = 0; k < total; k++) begin
            int p, h, v;
            p = k / D;
            h = p % htot();
            v = (p / htot()) % vtot();
            e[0] = (h < HS);
            e[1] = (v < VS);
            e[2] = (h >= HS + HBP && h < HS + HBP + HA && v >= VS + VBP && v < VS + VBP + VA);
            e[3] = h;
            e[4] = v;
            e[5] = ((k % D) == D - 1);
            e[6] = (e[5] != 0 && h == 0 && v == THR);
            a[0] = hsync; a[1] = vsync; a[2] = de; a[3] = h_pos;
            a[4] = v_pos; a[5] = pix_ce; a[6] = line_match;
            for (int j = 0; j < 7; j++) begin
                if (a[j] != e[j]) begin
                    if (nbad[j] == 0) begin fa[j] = a[j]; fe[j] = e[j]; end
                    nbad[j]++;
                end
            end
            @(negedge clk);
        end
        for (int j = 0; j < 7; j++)
            chk(nbad[j] == 0, tags[j], names[j], fa[j], fe[j]);
    endtask

    task automatic check_frame();
        wait_rise();
        check_body();
    endtask

    // R1: quiet outputs out of reset and while not enabled
    task automatic t_reset();
        chk(hsync == 0 && vsync == 0 && de == 0, "R1", "syncs/de after reset", {hsync, vsync, de}, 0);
        chk(frame_irq == 0 && line_match == 0 && pix_ce == 0, "R1", "irq/match/ce after reset",
            {frame_irq, line_match, pix_ce}, 0);
        repeat (20) @(negedge clk);
        chk(h_pos == 0 && v_pos == 0 && hsync == 0, "R1", "idle positions", h_pos + v_pos, 0);
    endtask

    // R2 R3 R4 R8: two back-to-back frames at ratio 1
    task automatic t_basic();
        D = 1; HS = 2; HBP = 3; HA = 8; HFP = 2;
        VS = 1; VBP = 2; VA = 4; VFP = 1; THR = 6;
        program_cfg();
        wr(3'd6, 32'h1);
        check_frame();
        check_body();
    endtask

    // R5: ratio 3
    task automatic t_div();
        wait_rise();
        D = 3;
        program_cfg();
        check_frame();
    endtask

    // R6: rewrite geometry mid-frame, the frame keeps its old length
    task automatic t_stage();
        longint c0, old_len;
        wait_rise();
        c0 = t_rise;
        old_len = D * htot() * vtot();
        D = 1; HS = 3; HBP = 2; HA = 10; HFP = 3;
        VS = 2; VBP = 1; VA = 5; VFP = 2; THR = 7;
        program_cfg();
        wait_rise();
        chk((t_rise - c0) == old_len, "R6", "frame length after mid-frame writes", t_rise - c0, old_len);
        check_body();
    endtask

    // R9 R10: enable gating and write-one clear
    task automatic t_irq();
        wr(3'd6, 32'h1);
        wait_rise(); @(negedge clk);
        chk(frame_irq == 0, "R9", "irq with no enables", frame_irq, 0);
        wr(3'd6, 32'h3);
        wait_rise(); @(negedge clk);
        chk(frame_irq == 0, "R9", "irq with master enable only", frame_irq, 0);
        wr(3'd6, 32'h5);
        wait_rise(); @(negedge clk);
        chk(frame_irq == 0, "R9", "irq with frame enable only", frame_irq, 0);
        wr(3'd6, 32'h7);
        wait_rise();
        chk(frame_irq == 0, "R9", "irq on vsync rise cycle", frame_irq, 0);
        @(negedge clk);
        chk(frame_irq == 1, "R9", "irq cycle after vsync rise", frame_irq, 1);
        wr(3'd7, 32'h0);
        chk(frame_irq == 1, "R10", "irq after clear write of zero", frame_irq, 1);
        wr(3'd7, 32'h1);
        chk(frame_irq == 0, "R10", "irq after clear write of one", frame_irq, 0);
        wr(3'd6, 32'h1);
    endtask

    // R7: disable mid-frame, frame completes, then idle
    task automatic t_stop();
        int total, hrises, vrises;
        bit hprev, vprev;
        longint hlast;
        total = D * htot() * vtot();
        wait_rise();
        wr(3'd6, 32'h0);
        hrises = 0; vrises = 0; hlast = -1;
        hprev = hsync; vprev = vsync;
        for (int k = 2; k <= 3 * total; k++) begin
            @(negedge clk);
            if (hsync && !hprev) hrises++;
            if (vsync && !vprev) vrises++;
            hprev = hsync; vprev = vsync;
            if (k == total - 1) hlast = h_pos;
        end
        chk(hrises == vtot() - 1, "R7", "lines started after disable", hrises, vtot() - 1);
        chk(vrises == 0, "R7", "new frames after disable", vrises, 0);
        chk(hlast == htot() - 1, "R7", "h_pos on last frame cycle", hlast, htot() - 1);
        chk(hsync == 0 && vsync == 0 && de == 0 && h_pos == 0 && v_pos == 0, "R1",
            "outputs idle after stop", {hsync, vsync, de}, 0);
    endtask

    // R7 R5: restart from idle with the largest ratio
    task automatic t_restart();
        D = 256; HS = 1; HBP = 1; HA = 1; HFP = 1;
        VS = 1; VBP = 1; VA = 1; VFP = 1; THR = 2;
        program_cfg();
        wr(3'd6, 32'h1);
        check_frame();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_div();
        t_stage();
        t_irq();
        t_stop();
        t_restart();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual %0d expected 0", 1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule